// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a group of general-purpose input pins and raises an interrupt when any pin chosen for monitoring no longer matches a snapshot of the port. The snapshot is taken whenever software reads or writes the port. A change is therefore measured against the last value software saw, not against the pin's value one clock earlier. Any difference sets a sticky flag. Software clears the flag after it has read the port. Reading the port refreshes the snapshot and ends the mismatch.

The flag is set again on every cycle in which a mismatch remains, so a clear only holds once the mismatch has gone. The snapshot register has no reset. After a reset, a mismatch that still exists sets the flag again. Pins reach the compare through a two-stage synchronizer. The flag is ANDed with an interrupt enable to form the request line, and the raw flag stays visible as an output. The reset input is asserted asynchronously and is expected to be released synchronously to `clk`.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst_n` is low the flag output `flag_o` is 0.
- R2: A pin change reaches the compare after two clock edges. A mismatch on an enabled pin sets `flag_o` on the third rising edge after the pin changes, provided no port access falls in that cycle.
- R3: A pin whose bit in `chg_en_i` is 0 never causes a mismatch, however it toggles.
- R4: While an enabled mismatch remains, `flag_o` is set on every cycle. A `flag_clr_i` pulse in a mismatch cycle has no effect, because setting wins over clearing.
- R5: A pulse on `rd_stb_i` or `wr_stb_i` reloads every bit of the snapshot from the synchronized pins. After that, `flag_clr_i` returns `flag_o` to 0 on the next edge and it stays 0.
- R6: In a cycle with a port access, no new set occurs. A synchronized change that arrives in the same cycle is captured into the snapshot and never raises the flag. Changes on several pins are all absorbed by one access.
- R7: The snapshot is kept through reset. If the pins differ from it when reset is released, `flag_o` is 1 after the first rising edge that follows the release.
- R8: `irq_o` equals `flag_o` when `irq_en_i` is 1, and is 0 otherwise. `flag_o` itself does not depend on `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released synchronously |
| pin_i | input | W | Raw pin levels |
| chg_en_i | input | W | Per-pin enable for change detection |
| rd_stb_i | input | 1 | One-cycle strobe for a port read |
| wr_stb_i | input | 1 | One-cycle strobe for a port write |
| flag_clr_i | input | 1 | One-cycle strobe that clears the flag |
| irq_en_i | input | 1 | Interrupt request enable |
| flag_o | output | 1 | Sticky change flag, not gated by the enable |
| irq_o | output | 1 | Interrupt request: flag AND enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flag set from a mismatch and a software clear. The bench holds `flag_clr_i` high while a mismatch remains and expects the flag to stay at 1. The second pair is a snapshot reload and a synchronized pin change. The bench places a read strobe at each offset from zero to four cycles after a pin edge. At the offset where the read lands exactly in the cycle the change reaches the compare, the flag must stay low. At the other offsets it must rise. A behavioural model in the bench delays the pins through a queue and judges the flag and request against it on every cycle, including during a long random phase.

// File: rtl/pci_pkg.sv
package pci_pkg;
  localparam int unsigned PCI_SYNC_MIN = 2;

  typedef struct packed {
    logic rd;
    logic wr;
    logic clr;
  } pci_bus_t;
endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = pci_pkg::PCI_SYNC_MIN
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= d_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk) begin
      stage_q[gi] <= stage_q[gi-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pci_snapshot.sv
module pci_snapshot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         load_i,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] copy_o,
  output logic         mism_o
);
  logic [W-1:0] copy_q;
  logic [W-1:0] diff;

  // no reset: the snapshot is kept through every reset
  always_ff @(posedge clk) begin
    if (load_i) begin
      copy_q <= pin_s_i;
    end
  end

  always_comb begin
    diff   = (pin_s_i ^ copy_q) & en_i;
    mism_o = |diff;
  end

  assign copy_o = copy_q;
endmodule

// File: rtl/pci_flag.sv
module pci_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mism_i,
  input  logic acc_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (mism_i && !acc_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] chg_en_i,
  input  logic         rd_stb_i,
  input  logic         wr_stb_i,
  input  logic         flag_clr_i,
  input  logic         irq_en_i,
  output logic         flag_o,
  output logic         irq_o
);
  import pci_pkg::*;

  pci_bus_t     bus;
  logic         acc;
  logic [W-1:0] pin_s;
  logic [W-1:0] copy_q;
  logic         mism;
  logic         flag_q;

  always_comb begin
    bus.rd  = rd_stb_i;
    bus.wr  = wr_stb_i;
    bus.clr = flag_clr_i;
    acc     = bus.rd | bus.wr;
  end

  pci_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  pci_snapshot #(.W(W)) snap_i (
    .clk     (clk),
    .load_i  (acc),
    .pin_s_i (pin_s),
    .en_i    (chg_en_i),
    .copy_o  (copy_q),
    .mism_o  (mism)
  );

  pci_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mism_i (mism),
    .acc_i  (acc),
    .clr_i  (bus.clr),
    .flag_o (flag_q)
  );

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/pci_chk.sv
module pci_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pin_s,
  input logic [W-1:0] copy_q,
  input logic [W-1:0] en,
  input logic         rd,
  input logic         wr,
  input logic         clr,
  input logic         flag
);
  logic live;
  logic acc;

  always_comb begin
    live = |((pin_s ^ copy_q) & en);
    acc  = rd | wr;
  end

  // R4
  mism_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !acc) |=> flag);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(live && !acc)) |=> !flag);

  // R5
  access_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (copy_q == $past(pin_s)));

  // R6
  idle_keeps_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(copy_q));

  // R3
  rise_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(live && !acc));
endmodule

bind pin_change_irq pci_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .pin_s  (pin_s),
  .copy_q (copy_q),
  .en     (chg_en_i),
  .rd     (rd_stb_i),
  .wr     (wr_stb_i),
  .clr    (flag_clr_i),
  .flag   (flag_q)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] pin;
  logic [W-1:0] en;
  logic         rd, wr, clr, ie;
  logic         flag_o, irq_o;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  // reference model state
  logic [W-1:0] pq[$];
  logic [W-1:0] m_copy;
  bit           m_copy_known = 0;
  bit           m_flag = 0;
  bit           m_valid = 0;

  always #10 clk = ~clk;

  pin_change_irq #(.W(W), .SYNC_STAGES(2)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin),
    .chg_en_i   (en),
    .rd_stb_i   (rd),
    .wr_stb_i   (wr),
    .flag_clr_i (clr),
    .irq_en_i   (ie),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  always @(negedge rst_n) m_flag = 0;

  always @(posedge clk) begin
    logic [W-1:0] ps;
    bit psk;
    bit mm;
    bit acc;
    psk = (pq.size() >= 2);
    ps  = psk ? pq[pq.size()-2] : '0;
    if (!rst_n) begin
      m_flag = 0;
    end else begin
      acc = rd | wr;
      mm  = psk && m_copy_known && (((ps ^ m_copy) & en) != '0);
      if (mm && !acc) m_flag = 1;
      else if (clr)   m_flag = 0;
      if (acc && clr && psk) m_valid = 1;
      if (acc && psk) begin
        m_copy = ps;
        m_copy_known = 1;
      end
    end
    pq.push_back(pin);
    if (pq.size() > 3) void'(pq.pop_front());
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // waits for the falling edge and compares the outputs with the model
  task automatic tick(input string tag);
    @(negedge clk);
    if (m_valid && rst_n) begin
      check(flag_o === m_flag, tag, int'(flag_o), int'(m_flag));
      check(irq_o === (m_flag & ie), {tag, " / R8 request"}, int'(irq_o), int'(m_flag & ie));
    end
  endtask

  task automatic idle();
    rd = 0; wr = 0; clr = 0;
  endtask

  task automatic service(input bit use_wr, input string tag);
    rd = !use_wr; wr = use_wr; clr = 1;
    tick(tag);
    idle();
    tick(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin = '0; en = '1; ie = 0; idle();
    repeat (4) begin
      @(negedge clk);
      check(flag_o === 1'b0, "R1 flag low in reset", int'(flag_o), 0);
    end
    rst_n = 1;
    repeat (3) tick("startup");
    service(0, "R5 initial read and clear");
    check(m_valid == 1, "R5 model armed", int'(m_valid), 1);

    // R2 latency: flag appears on third edge after pin change
    pin[0] = 1;
    tick("R2 sync stage 1");
    check(flag_o === 1'b0, "R2 no flag after one edge", int'(flag_o), 0);
    tick("R2 sync stage 2");
    check(flag_o === 1'b0, "R2 no flag after two edges", int'(flag_o), 0);
    tick("R2 flag set");
    check(flag_o === 1'b1, "R2 flag after three edges", int'(flag_o), 1);

    // R4 clear loses against a live mismatch
    clr = 1;
    repeat (3) tick("R4 clear during mismatch");
    check(flag_o === 1'b1, "R4 set wins over clear", int'(flag_o), 1);
    idle();
    service(0, "R5 read ends mismatch");
    repeat (3) tick("R5 flag stays clear");
    check(flag_o === 1'b0, "R5 flag cleared after read", int'(flag_o), 0);

    // R5 write strobe also reloads
    pin[1] = 1;
    repeat (4) tick("R2 second pin");
    service(1, "R5 write ends mismatch");
    repeat (2) tick("R5 after write");
    check(flag_o === 1'b0, "R5 flag cleared after write", int'(flag_o), 0);

    // R3 disabled pin toggles
    en = 8'hFB;
    for (int k = 0; k < 6; k++) begin
      pin[2] = ~pin[2];
      repeat (3) tick("R3 disabled pin");
    end
    check(flag_o === 1'b0, "R3 disabled pin ignored", int'(flag_o), 0);
    en = '1;
    service(0, "R3 resync");

    // R6 read at offsets around the arrival of a change
    for (int off = 0; off < 5; off++) begin
      pin[3] = ~pin[3];
      for (int t = 0; t < off; t++) tick("R6 wait");
      rd = 1;
      tick("R6 read near change");
      idle();
      repeat (3) tick("R6 settle");
      if (off == 2)
        check(flag_o === 1'b0, "R6 change absorbed by read", int'(flag_o), 0);
      else
        check(flag_o === 1'b1, "R6 change flagged", int'(flag_o), 1);
      service(0, "R6 clean up");
    end

    // R6 two pins absorbed by one service access
    pin[4] = 1;
    repeat (4) tick("R6 first pin");
    pin[5] = 1;
    repeat (2) tick("R6 second pin in flight");
    service(0, "R6 service both");
    repeat (4) tick("R6 both absorbed");
    check(flag_o === 1'b0, "R6 second pin lost", int'(flag_o), 0);

    // R8 enable gating
    pin[6] = 1;
    ie = 0;
    repeat (4) tick("R8 gated");
    check(irq_o === 1'b0 && flag_o === 1'b1, "R8 raw flag with request masked", int'(irq_o), 0);
    ie = 1;
    tick("R8 enabled");
    check(irq_o === 1'b1, "R8 request follows flag", int'(irq_o), 1);
    service(0, "R8 clean up");

    // R7 snapshot survives reset
    pin[7] = 1;
    repeat (3) tick("R7 mismatch before reset");
    rst_n = 0;
    repeat (3) begin
      @(negedge clk);
      check(flag_o === 1'b0, "R1 flag low in second reset", int'(flag_o), 0);
    end
    rst_n = 1;
    tick("R7 first edge after reset");
    check(flag_o === 1'b1, "R7 retained snapshot re-flags", int'(flag_o), 1);
    service(0, "R7 clean up");
    check(flag_o === 1'b0, "R7 cleared after read", int'(flag_o), 0);

    // random phase compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      rd  = ($urandom_range(0, 9) == 0);
      wr  = ($urandom_range(0, 14) == 0);
      clr = ($urandom_range(0, 3) == 0);
      ie  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 4) == 0) pin[$urandom_range(0, W-1)] ^= 1'b1;
      if ($urandom_range(0, 49) == 0) en = W'($urandom);
      tick("R4 random traffic");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule